// File: doc/BRIEF.md
# Dataflow Token Matching Pipeline

This block executes dataflow graphs using an explicit operand store. A token names a frame (a base address in operand storage), the instruction it feeds, the input port it arrives on (left or right) and a data value. The code memory is shared by every frame. Each frame gives every two-input operator a single slot that holds one waiting operand and a presence flag. The first operand to reach an operator waits in that slot. Its partner then sends both values through the arithmetic unit, and the result is sent on to up to two destinations in the same frame. Because the code and the operand storage are kept apart, several invocations of one graph can be in flight at once, each in its own frame.

Tokens enter through a queue and pass through four stages: the queue, instruction fetch, operand match, and the arithmetic unit. A formation stage after the arithmetic unit then emits the results. Each result either goes back to the queue or leaves through the output port. Code and operand memories are written from outside through plain write ports. Frame allocation and any interconnect lie outside the block.

Top module: `etp_pipe`

## Requirements
- R1: After reset the queue and all stages are empty, every presence flag is clear, `out_valid` is 0 and `in_ready` is 1.
- R2: A token reaching a two-input instruction whose slot flag is clear stores its value in the slot and sets the flag. It produces no output and no internal token.
- R3: A token reaching a two-input instruction whose slot flag is set clears the flag and fires the operator. The value that arrived on port 0 (left) is always the first operand, whatever the order of arrival.
- R4: Opcode (3 bits) meanings: 0 add, 1 subtract (first minus second), 2 multiply keeping the low DATA_W bits, 3 bitwise AND, 4 pass, 5 increment, 6 shift left by one, 7 two's-complement negate. Opcodes 4 to 7 have one input and skip the frame match entirely.
- R5: The slot address is the token's frame pointer plus the instruction's 3-bit offset, modulo 32. Frames at different bases hold their waiting operands independently while running the same code.
- R6: Each emitted token keeps the firing token's frame pointer and takes its instruction pointer and port from the destination. A destination with the enable bit clear emits nothing. One with the external bit set leaves on the output port, and one with it clear re-enters the queue. Destination 0 is emitted before destination 1, at one token per cycle.
- R7: Internally formed tokens have priority at the queue's write port. `in_ready` is 0 in every cycle in which the formation stage pushes into the queue, and whenever the queue is full. A full queue with an internal token pending stalls the pipeline.
- R8: `code_we` writes `code_wdata` into code location `code_addr`. Word layout, MSB first: opcode[19:17], offset[16:14], destination 1 [13:7], destination 0 [6:0]. Each destination is enable[6], external[5], ip[4:1], port[0].
- R9: `frame_we` writes `frame_wdata` and the presence flag `frame_wpres` into slot `frame_addr`. This overrides any update the pipeline makes to the slot in the same cycle.
- R10: A one-input instruction leaves a waiting operand in the slot at its own offset untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | External token offered |
| in_fp | input | 5 | Frame pointer of the offered token |
| in_ip | input | 4 | Instruction pointer of the offered token |
| in_port | input | 1 | Port of the offered token (0 left, 1 right) |
| in_data | input | 8 | Data of the offered token |
| in_ready | output | 1 | Offered token is accepted at this edge |
| code_we | input | 1 | Code memory write enable |
| code_addr | input | 4 | Code memory write address |
| code_wdata | input | 20 | Instruction word |
| frame_we | input | 1 | Operand memory write enable |
| frame_addr | input | 5 | Operand slot address |
| frame_wdata | input | 8 | Operand value to store |
| frame_wpres | input | 1 | Presence flag to store |
| out_valid | output | 1 | Output token present this cycle |
| out_fp | output | 5 | Output token frame pointer |
| out_ip | output | 4 | Output token instruction pointer |
| out_port | output | 1 | Output token port |
| out_data | output | 8 | Output token data |

## Verification
The bench sweeps every opcode over operand pairs that include 0, 1 and 255, sending the two operands in both arrival orders. A design that ordered operands by arrival instead of by port would then fail on subtraction. Frame bases run up to 31, so an offset that did not wrap modulo 32 would miss its slot. The bench also interleaves two frames of one graph, forks a result to three outputs, checks the stall cycles in `in_ready` while tokens are pushed internally, and overwrites a waiting operand through the load port. A design that shared slots across frames, reordered destinations, let a one-input instruction disturb a waiting operand or ignored the load would produce wrong or missing output tokens.

// File: rtl/etp_pkg.sv
package etp_pkg;

    localparam int DATA_W      = 8;
    localparam int IP_W        = 4;
    localparam int FADDR_W     = 5;
    localparam int OFF_W       = 3;
    localparam int CODE_DEPTH  = 1 << IP_W;
    localparam int FRAME_DEPTH = 1 << FADDR_W;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_PASS = 3'd4,
        OP_INC  = 3'd5,
        OP_DBL  = 3'd6,
        OP_NEG  = 3'd7
    } op_e;

    typedef struct packed {
        logic            en;
        logic            ext;
        logic [IP_W-1:0] ip;
        logic            port;
    } dest_t;

    typedef struct packed {
        op_e              op;
        logic [OFF_W-1:0] off;
        dest_t            d1;
        dest_t            d0;
    } instr_t;

    typedef struct packed {
        logic [FADDR_W-1:0] fp;
        logic [IP_W-1:0]    ip;
        logic               port;
        logic [DATA_W-1:0]  data;
    } token_t;

    typedef struct packed {
        logic              pres;
        logic [DATA_W-1:0] data;
    } slot_t;

    localparam int INSTR_W = $bits(instr_t);

    function automatic logic is_monadic(op_e op);
        return op[2];
    endfunction

endpackage

// File: rtl/etp_token_queue.sv
module etp_token_queue
    import etp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  token_t wr_tok,
    input  logic   rd_en,
    output token_t rd_tok,
    output logic   empty,
    output logic   full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        token_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (wr_en) begin
            q_d.mem[q_q.wr] = wr_tok;
            q_d.wr = (q_q.wr == PTR_W'(DEPTH - 1)) ? '0 : q_q.wr + PTR_W'(1);
        end
        if (rd_en) begin
            q_d.rd = (q_q.rd == PTR_W'(DEPTH - 1)) ? '0 : q_q.rd + PTR_W'(1);
        end
        case ({wr_en, rd_en})
            2'b10:   q_d.cnt = q_q.cnt + CNT_W'(1);
            2'b01:   q_d.cnt = q_q.cnt - CNT_W'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign rd_tok = q_q.mem[q_q.rd];
    assign empty  = (q_q.cnt == '0);
    assign full   = (q_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R7

endmodule

// File: rtl/etp_frame_store.sv
module etp_frame_store
    import etp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [FADDR_W-1:0] lk_addr,
    input  logic [DATA_W-1:0]  lk_data,
    output logic               lk_hit,
    output logic [DATA_W-1:0]  lk_stored,
    input  logic               ld_we,
    input  logic [FADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic               ld_pres
);
    typedef struct packed {
        slot_t [FRAME_DEPTH-1:0] slot;
    } fs_t;

    fs_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (lk_valid) begin
            if (fs_q.slot[lk_addr].pres) begin
                fs_d.slot[lk_addr].pres = 1'b0;
            end else begin
                fs_d.slot[lk_addr].pres = 1'b1;
                fs_d.slot[lk_addr].data = lk_data;
            end
        end
        if (ld_we) begin
            fs_d.slot[ld_addr].pres = ld_pres;
            fs_d.slot[ld_addr].data = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign lk_hit    = fs_q.slot[lk_addr].pres;
    assign lk_stored = fs_q.slot[lk_addr].data;

    AST_PARK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !ld_we) |=>
            (fs_q.slot[$past(lk_addr)].pres && fs_q.slot[$past(lk_addr)].data == $past(lk_data))); // R2
    AST_FIRE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && !ld_we) |=> !fs_q.slot[$past(lk_addr)].pres); // R3

endmodule

// File: rtl/etp_alu.sv
module etp_alu
    import etp_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DATA_W-1:0];
            OP_AND:  y = a & b;
            OP_PASS: y = a;
            OP_INC:  y = a + DATA_W'(1);
            OP_DBL:  y = {a[DATA_W-2:0], 1'b0};
            default: y = DATA_W'(0) - a;
        endcase
    end

endmodule

// File: rtl/etp_pipe.sv
module etp_pipe
    import etp_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FADDR_W-1:0] in_fp,
    input  logic [IP_W-1:0]    in_ip,
    input  logic               in_port,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    input  logic               code_we,
    input  logic [IP_W-1:0]    code_addr,
    input  logic [INSTR_W-1:0] code_wdata,
    input  logic               frame_we,
    input  logic [FADDR_W-1:0] frame_addr,
    input  logic [DATA_W-1:0]  frame_wdata,
    input  logic               frame_wpres,
    output logic               out_valid,
    output logic [FADDR_W-1:0] out_fp,
    output logic [IP_W-1:0]    out_ip,
    output logic               out_port,
    output logic [DATA_W-1:0]  out_data
);
    typedef struct packed {
        instr_t [CODE_DEPTH-1:0] code;
        logic                    s1_v;
        token_t                  s1_tok;
        instr_t                  s1_ins;
        logic                    s2_v;
        op_e                     s2_op;
        logic [DATA_W-1:0]       s2_a;
        logic [DATA_W-1:0]       s2_b;
        logic [FADDR_W-1:0]      s2_fp;
        dest_t                   s2_d0;
        dest_t                   s2_d1;
        logic                    s3_v;
        logic [DATA_W-1:0]       s3_res;
        logic [FADDR_W-1:0]      s3_fp;
        dest_t                   s3_d0;
        dest_t                   s3_d1;
        logic [1:0]              s3_pend;
    } pipe_t;

    pipe_t st_d, st_q;

    logic               q_wr_en, q_rd_en, q_empty, q_full, q_wr_int;
    token_t             q_wr_tok, q_head, emit_tok;
    logic               lk_valid, lk_hit, mono, hold, sel_d1, emit_req, emit_done;
    logic [FADDR_W-1:0] lk_addr;
    logic [DATA_W-1:0]  lk_stored, alu_y;
    logic [1:0]         pend_next;
    dest_t              cur;
    instr_t             fetched;

    etp_token_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (q_wr_en),
        .wr_tok (q_wr_tok),
        .rd_en  (q_rd_en),
        .rd_tok (q_head),
        .empty  (q_empty),
        .full   (q_full)
    );

    etp_frame_store u_frames (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .lk_data   (st_q.s1_tok.data),
        .lk_hit    (lk_hit),
        .lk_stored (lk_stored),
        .ld_we     (frame_we),
        .ld_addr   (frame_addr),
        .ld_data   (frame_wdata),
        .ld_pres   (frame_wpres)
    );

    etp_alu u_alu (
        .op (st_q.s2_op),
        .a  (st_q.s2_a),
        .b  (st_q.s2_b),
        .y  (alu_y)
    );

    always_comb begin
        st_d = st_q;

        // token formation: one destination per cycle, destination 0 first
        sel_d1    = !st_q.s3_pend[0];
        cur       = sel_d1 ? st_q.s3_d1 : st_q.s3_d0;
        emit_req  = st_q.s3_v && (st_q.s3_pend != 2'b00);
        emit_tok  = '{fp: st_q.s3_fp, ip: cur.ip, port: cur.port, data: st_q.s3_res};
        q_wr_int  = emit_req && !cur.ext && !q_full;
        out_valid = emit_req && cur.ext;
        out_fp    = emit_tok.fp;
        out_ip    = emit_tok.ip;
        out_port  = emit_tok.port;
        out_data  = emit_tok.data;
        emit_done = out_valid || q_wr_int;
        pend_next = st_q.s3_pend;
        if (emit_done) pend_next[sel_d1] = 1'b0;
        hold      = st_q.s3_v && (pend_next != 2'b00);
        st_d.s3_pend = pend_next;

        // queue write port: internal tokens first
        in_ready = !q_full && !q_wr_int;
        q_wr_en  = q_wr_int || (in_valid && in_ready);
        q_wr_tok = q_wr_int ? emit_tok
                            : '{fp: in_fp, ip: in_ip, port: in_port, data: in_data};

        // fetch and operand match
        q_rd_en  = !hold && !q_empty;
        fetched  = st_q.code[q_head.ip];
        mono     = is_monadic(st_q.s1_ins.op);
        lk_valid = !hold && st_q.s1_v && !mono;
        lk_addr  = st_q.s1_tok.fp + FADDR_W'(st_q.s1_ins.off);

        if (!hold) begin
            st_d.s1_v   = q_rd_en;
            st_d.s1_tok = q_head;
            st_d.s1_ins = fetched;

            st_d.s2_v  = st_q.s1_v && (mono || lk_hit);
            st_d.s2_op = st_q.s1_ins.op;
            st_d.s2_fp = st_q.s1_tok.fp;
            st_d.s2_d0 = st_q.s1_ins.d0;
            st_d.s2_d1 = st_q.s1_ins.d1;
            if (mono) begin
                st_d.s2_a = st_q.s1_tok.data;
                st_d.s2_b = '0;
            end else if (!st_q.s1_tok.port) begin
                st_d.s2_a = st_q.s1_tok.data;
                st_d.s2_b = lk_stored;
            end else begin
                st_d.s2_a = lk_stored;
                st_d.s2_b = st_q.s1_tok.data;
            end

            st_d.s3_v    = st_q.s2_v;
            st_d.s3_res  = alu_y;
            st_d.s3_fp   = st_q.s2_fp;
            st_d.s3_d0   = st_q.s2_d0;
            st_d.s3_d1   = st_q.s2_d1;
            st_d.s3_pend = st_q.s2_v ? {st_q.s2_d1.en, st_q.s2_d0.en} : 2'b00;
        end

        if (code_we) st_d.code[code_addr] = code_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_FREEZES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s3_v && hold) |=> ($stable(st_q.s3_res) && $stable(st_q.s3_fp) && st_q.s3_v)); // R6
    AST_PARK_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && !mono && !lk_hit && !hold) |=> !st_q.s2_v); // R2
    AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !q_rd_en); // R7

endmodule

// File: tb/etp_pipe_tb.sv
module etp_pipe_tb;
    import etp_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [FADDR_W-1:0] in_fp = '0;
    logic [IP_W-1:0]    in_ip = '0;
    logic               in_port = 1'b0;
    logic [DATA_W-1:0]  in_data = '0;
    logic               in_ready;
    logic               code_we = 1'b0;
    logic [IP_W-1:0]    code_addr = '0;
    logic [INSTR_W-1:0] code_wdata = '0;
    logic               frame_we = 1'b0;
    logic [FADDR_W-1:0] frame_addr = '0;
    logic [DATA_W-1:0]  frame_wdata = '0;
    logic               frame_wpres = 1'b0;
    logic               out_valid;
    logic [FADDR_W-1:0] out_fp;
    logic [IP_W-1:0]    out_ip;
    logic               out_port;
    logic [DATA_W-1:0]  out_data;

    always #5 clk = ~clk;

    etp_pipe #(.QDEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_fp(in_fp), .in_ip(in_ip), .in_port(in_port),
        .in_data(in_data), .in_ready(in_ready),
        .code_we(code_we), .code_addr(code_addr), .code_wdata(code_wdata),
        .frame_we(frame_we), .frame_addr(frame_addr), .frame_wdata(frame_wdata),
        .frame_wpres(frame_wpres),
        .out_valid(out_valid), .out_fp(out_fp), .out_ip(out_ip),
        .out_port(out_port), .out_data(out_data)
    );

    int n_chk = 0;
    int n_err = 0;
    token_t cap [1024];
    int ncap = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 1024) begin
            cap[ncap] = '{fp: out_fp, ip: out_ip, port: out_port, data: out_data};
            ncap = ncap + 1;
        end
    end

    task automatic chk(input string req, input logic ok, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic dest_t dst(input bit en, input bit ext, input int ip, input bit port);
        return '{en: en, ext: ext, ip: IP_W'(ip), port: port};
    endfunction

    function automatic logic [DATA_W-1:0] model(input int op, input int a, input int b);
        logic [DATA_W-1:0] x, y;
        x = DATA_W'(a);
        y = DATA_W'(b);
        case (op)
            0: return x + y;
            1: return x - y;
            2: return DATA_W'(a * b);
            3: return x & y;
            4: return x;
            5: return x + 8'd1;
            6: return DATA_W'(a * 2);
            default: return 8'd0 - x;
        endcase
    endfunction

    function automatic int find(input int base, input int fp, input int ip,
                                input int port, input int data);
        int hits = 0;
        for (int i = base; i < ncap; i++)
            if (cap[i].fp == FADDR_W'(fp) && cap[i].ip == IP_W'(ip) &&
                cap[i].port == 1'(port) && cap[i].data == DATA_W'(data))
                hits++;
        return hits;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_code(input int addr, input op_e op, input int off,
                             input dest_t d0, input dest_t d1);
        instr_t w;
        w = '{op: op, off: OFF_W'(off), d1: d1, d0: d0};
        @(negedge clk);
        code_we = 1'b1; code_addr = IP_W'(addr); code_wdata = w;
        @(negedge clk);
        code_we = 1'b0;
    endtask

    task automatic load_frame(input int addr, input int data, input bit pres);
        @(negedge clk);
        frame_we = 1'b1; frame_addr = FADDR_W'(addr);
        frame_wdata = DATA_W'(data); frame_wpres = pres;
        @(negedge clk);
        frame_we = 1'b0;
    endtask

    task automatic send(input int fp, input int ip, input bit port, input int data);
        @(negedge clk);
        in_valid = 1'b1; in_fp = FADDR_W'(fp); in_ip = IP_W'(ip);
        in_port = port; in_data = DATA_W'(data);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int vals [4] = '{0, 1, 100, 255};
        int base, trial, fp, first, second;
        logic [DATA_W-1:0] exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
        chk("R1", in_ready == 1'b1, "in_ready after reset", int'(in_ready), 1);

        // R3 R4 R5: every two-input opcode, operand pairs, both arrival orders
        trial = 0;
        for (int op = 0; op < 4; op++) begin
            load_code(0, op_e'(op), 1, dst(1, 1, 7, 1), dst(0, 0, 0, 0));
            for (int ia = 0; ia < 4; ia++) begin
                for (int ib = 0; ib < 4; ib++) begin
                    for (int ord = 0; ord < 2; ord++) begin
                        fp = (trial * 7 + 31) % 32;
                        trial++;
                        base = ncap;
                        if (ord == 0) send(fp, 0, 1'b0, vals[ia]);
                        else          send(fp, 0, 1'b1, vals[ib]);
                        idle(6);
                        chk("R2", ncap == base, "first arrival emitted tokens", ncap - base, 0);
                        if (ord == 0) send(fp, 0, 1'b1, vals[ib]);
                        else          send(fp, 0, 1'b0, vals[ia]);
                        idle(6);
                        exp = model(op, vals[ia], vals[ib]);
                        chk("R3", ncap - base == 1, "fired token count", ncap - base, 1);
                        chk("R4", find(base, fp, 7, 1, int'(exp)) == 1, "op result",
                            int'(cap[base].data), int'(exp));
                    end
                end
            end
        end

        // R4 R10: one-input opcodes
        for (int op = 4; op < 8; op++) begin
            load_code(2, op_e'(op), 0, dst(1, 1, 6, 0), dst(0, 0, 0, 0));
            for (int ia = 0; ia < 4; ia++) begin
                base = ncap;
                send(9, 2, 1'b0, vals[ia]);
                idle(6);
                exp = model(op, vals[ia], 0);
                chk("R4", ncap - base == 1 && find(base, 9, 6, 0, int'(exp)) == 1,
                    "one-input result", int'(cap[base].data), int'(exp));
            end
        end

        // R10: one-input instruction does not disturb a waiting operand
        load_code(0, OP_SUB, 1, dst(1, 1, 7, 1), dst(0, 0, 0, 0));
        load_code(3, OP_INC, 1, dst(1, 1, 8, 0), dst(0, 0, 0, 0));
        base = ncap;
        send(2, 0, 1'b0, 50);
        idle(6);
        send(2, 3, 1'b1, 9);
        idle(6);
        chk("R10", find(base, 2, 8, 0, 10) == 1, "one-input output", ncap - base, 1);
        send(2, 0, 1'b1, 20);
        idle(6);
        chk("R10", find(base, 2, 7, 1, 30) == 1, "waiting operand kept", ncap - base, 2);

        // R9: operand loaded from outside, then a load that clears a waiting operand
        base = ncap;
        load_frame(7, 40, 1'b1);
        send(6, 0, 1'b1, 10);
        idle(6);
        chk("R9", ncap - base == 1 && find(base, 6, 7, 1, 30) == 1, "loaded operand fires",
            ncap - base, 1);
        base = ncap;
        send(6, 0, 1'b0, 77);
        idle(6);
        load_frame(7, 0, 1'b0);
        send(6, 0, 1'b1, 5);
        idle(6);
        chk("R9", ncap == base, "cleared slot parks again", ncap - base, 0);
        send(6, 0, 1'b0, 60);
        idle(6);
        chk("R9", ncap - base == 1 && find(base, 6, 7, 1, 55) == 1, "fires with new pair",
            ncap - base, 1);

        // R5 R6 R8: fork graph in two interleaved frames
        load_code(0, OP_ADD, 2, dst(1, 0, 1, 0), dst(1, 0, 2, 0));
        load_code(1, OP_DBL, 0, dst(1, 1, 9, 0), dst(0, 0, 0, 0));
        load_code(2, OP_NEG, 0, dst(1, 1, 10, 1), dst(1, 1, 11, 0));
        base = ncap;
        send(3, 0, 1'b0, 5);
        send(12, 0, 1'b0, 20);
        send(12, 0, 1'b1, 1);
        send(3, 0, 1'b1, 6);
        idle(20);
        chk("R6", ncap - base == 6, "graph output count", ncap - base, 6);
        chk("R5", find(base, 3, 9, 0, 22) == 1, "frame 3 doubled", ncap - base, 6);
        chk("R6", find(base, 3, 10, 1, 245) == 1, "frame 3 dest0", ncap - base, 6);
        chk("R6", find(base, 3, 11, 0, 245) == 1, "frame 3 dest1", ncap - base, 6);
        chk("R5", find(base, 12, 9, 0, 42) == 1, "frame 12 doubled", ncap - base, 6);
        chk("R6", find(base, 12, 10, 1, 235) == 1, "frame 12 dest0", ncap - base, 6);
        chk("R6", find(base, 12, 11, 0, 235) == 1, "frame 12 dest1", ncap - base, 6);
        first = -1; second = -1;
        for (int i = base; i < ncap; i++) begin
            if (cap[i].fp == 5'd3 && cap[i].ip == 4'd10) first = i;
            if (cap[i].fp == 5'd3 && cap[i].ip == 4'd11) second = i;
        end
        chk("R6", second == first + 1, "dest0 directly before dest1", second, first + 1);

        // R7: in_ready drops during the two internal pushes of a fired ADD
        @(negedge clk);
        in_valid = 1'b1; in_fp = 5'd20; in_ip = 4'd0; in_port = 1'b0; in_data = 8'd2;
        @(negedge clk);
        in_port = 1'b1; in_data = 8'd3;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7", in_ready == 1'b1, "in_ready before formation", int'(in_ready), 1);
        @(negedge clk);
        chk("R7", in_ready == 1'b0, "in_ready during push of dest0", int'(in_ready), 0);
        @(negedge clk);
        chk("R7", in_ready == 1'b0, "in_ready during push of dest1", int'(in_ready), 0);
        base = ncap;
        idle(12);
        chk("R7", find(base, 20, 9, 0, 10) == 1 && find(base, 20, 10, 1, 251) == 1,
            "internal tokens completed", ncap - base, 3);
        chk("R1", in_ready == 1'b1, "in_ready when idle", int'(in_ready), 1);

        report();
    end

endmodule